// File: doc/BRIEF.md
# Raster Scan Timing Backend for a Line-Buffered Display

This block runs on the pixel clock of a display panel. It counts columns and lines of a raster frame and drives active-low horizontal and vertical sync and a data-enable strobe. It also places the blanking intervals on either side of each sync pulse. By default the frame is 640 by 480 visible pixels, in an 800-clock line and a 525-line frame.

The block does not make pixels itself. It drives a column address into the read port of a dual-port line buffer that is filled from another clock domain. That port returns an 18-bit word one clock later, which the block splits into three 6-bit colour channels. To keep the buffer filled in time, the block flips a line-request level once for each visible line that is about to be shown. The fetch side passes this level through its own synchronizer and loads the next line while the current blanking interval runs.

Top module: `tft_scan_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the column and line counters return to zero. After that edge `de` is 0, `hsync_n` and `vsync_n` are 1, `rd_col` is 0 and `line_req_tgl` is 0.
- R2: A line lasts H_ACT+H_FP+H_SYNC+H_BP clocks (800 by default). The first H_ACT counter positions of each line (640 by default) are the visible columns.
- R3: `hsync_n` is low for H_SYNC clocks, starting H_ACT+H_FP clocks into the line, and high for the rest of the line.
- R4: A frame lasts V_ACT+V_FP+V_SYNC+V_BP lines (525 by default). `vsync_n` is low through lines V_ACT+V_FP to V_ACT+V_FP+V_SYNC-1 and high on all other lines.
- R5: `de` is high exactly on the visible columns of the first V_ACT lines, and low on every other clock.
- R6: `rd_col` carries the column of the current counter position while that position is visible, and 0 otherwise. It therefore leads the matching `de` cycle by one clock.
- R7: While `de` is high, `red`, `green` and `blue` equal bits 17:12, 11:6 and 5:0 of `rd_pix`. While `de` is low, all three are 0, whatever `rd_pix` holds.
- R8: `line_req_tgl` flips at the edge that ends the visible part of lines 0 to V_ACT-2. It also flips at the same column of the last line of the frame. It never changes at any other edge, so it flips V_ACT times per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_col | output | COL_W (10) | Column address to the line buffer read port |
| rd_pix | input | 3*CH_W (18) | Word returned by the line buffer one clock after the address |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, high on visible pixels |
| red | output | CH_W (6) | Red channel |
| green | output | CH_W (6) | Green channel |
| blue | output | CH_W (6) | Blue channel |
| line_req_tgl | output | 1 | Line-request level, flipped once per line to be fetched |

## Verification
A column counter that is off by even one position shifts `hsync_n` against `de` within the same line. It also breaks the one-clock lead of `rd_col` over `de`, so such a fault shows up within a few hundred clocks. A line counter fault moves `vsync_n` or the visible window and changes how many request flips happen in a frame. This becomes visible at the first frame boundary. The toggle count is checked against an independent count at every clock over two frames, so a request that is missing or extra shows up as a parity error on the first line where it occurs.

// File: rtl/tft_scan_timer.sv
`timescale 1ns/1ps
module tft_scan_timer #(
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int COL_W  = 10,
  parameter int CH_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  output logic [COL_W-1:0]  rd_col,
  input  logic [3*CH_W-1:0] rd_pix,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              de,
  output logic [CH_W-1:0]   red,
  output logic [CH_W-1:0]   green,
  output logic [CH_W-1:0]   blue,
  output logic              line_req_tgl
);
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW = $clog2(H_TOT);
  localparam int VW = $clog2(V_TOT);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [HW-1:0] H_VIS  = HW'(H_ACT);
  localparam logic [HW-1:0] H_SS   = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] H_SE   = HW'(H_ACT + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [VW-1:0] V_VIS  = VW'(V_ACT);
  localparam logic [VW-1:0] V_PRE  = VW'(V_ACT - 1);
  localparam logic [VW-1:0] V_SS   = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] V_SE   = VW'(V_ACT + V_FP + V_SYNC);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;

  wire h_end  = (hcnt == H_LAST);
  wire v_end  = (vcnt == V_LAST);
  wire vis    = (hcnt < H_VIS) && (vcnt < V_VIS);
  wire hs_win = (hcnt >= H_SS) && (hcnt < H_SE);
  wire vs_win = (vcnt >= V_SS) && (vcnt < V_SE);
  wire req    = (hcnt == H_VIS) && ((vcnt < V_PRE) || v_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= h_end ? '0 : hcnt + 1'b1;
      if (h_end) vcnt <= v_end ? '0 : vcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      de           <= 1'b0;
      hsync_n      <= 1'b1;
      vsync_n      <= 1'b1;
      line_req_tgl <= 1'b0;
    end else begin
      de           <= vis;
      hsync_n      <= ~hs_win;
      vsync_n      <= ~vs_win;
      line_req_tgl <= line_req_tgl ^ req;
    end
  end

  assign rd_col = vis ? COL_W'(hcnt) : '0;
  assign red    = de ? rd_pix[3*CH_W-1:2*CH_W] : '0;
  assign green  = de ? rd_pix[2*CH_W-1:CH_W]   : '0;
  assign blue   = de ? rd_pix[CH_W-1:0]        : '0;
endmodule

// File: rtl/tft_scan_timer_chk.sv
`timescale 1ns/1ps
module tft_scan_timer_chk #(
  parameter int HW = 10,
  parameter int VW = 10,
  parameter int H_LIM = 800,
  parameter int V_LIM = 525,
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [HW-1:0]    hcnt,
  input logic [VW-1:0]    vcnt,
  input logic [COL_W-1:0] rd_col,
  input logic             de,
  input logic             hsync_n,
  input logic             vsync_n,
  input logic             line_req_tgl
);
  localparam logic [HW-1:0] H_MAX = HW'(H_LIM - 1);
  localparam logic [VW-1:0] V_MAX = VW'(V_LIM - 1);

  always @(posedge clk) begin
    if (!rst) begin
      a_r2_hcnt_range: assert (hcnt <= H_MAX);
      a_r4_vcnt_range: assert (vcnt <= V_MAX);
    end
  end

  a_r3_hsync_blank: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> !de);

  a_r4_vsync_blank: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> (!de && rd_col == '0));

  a_r6_col_leads_de: assert property (@(posedge clk) disable iff (rst)
    (rd_col != '0) |=> de);

  a_r6_col_steps: assert property (@(posedge clk) disable iff (rst)
    (rd_col != '0 && $past(rd_col) != '0) |-> rd_col == $past(rd_col) + 1'b1);

  a_r8_req_in_blank: assert property (@(posedge clk) disable iff (rst)
    (line_req_tgl != $past(line_req_tgl)) |-> !de);
endmodule

bind tft_scan_timer tft_scan_timer_chk #(
  .HW(HW), .VW(VW), .H_LIM(H_TOT), .V_LIM(V_TOT), .COL_W(COL_W)
) u_chk (
  .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .rd_col(rd_col),
  .de(de), .hsync_n(hsync_n), .vsync_n(vsync_n), .line_req_tgl(line_req_tgl)
);

// File: tb/tft_scan_timer_tb.sv
`timescale 1ns/1ps
module tft_scan_timer_tb_top;
  localparam int PERIOD = 10;
  localparam int HA = 16, HF = 2, HS = 4, HB = 3;
  localparam int VA = 6, VF = 2, VS = 2, VB = 3;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] rd_col;
  logic [17:0] rd_pix = '0;
  logic hsync_n, vsync_n, de, line_req_tgl;
  logic [5:0] red, green, blue;
  int checks = 0;
  int errors = 0;
  int n = 0;

  always #(PERIOD/2) clk = ~clk;

  tft_scan_timer #(
    .H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .COL_W(10), .CH_W(6)
  ) dut_i (
    .clk(clk), .rst(rst), .rd_col(rd_col), .rd_pix(rd_pix),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
    .red(red), .green(green), .blue(blue), .line_req_tgl(line_req_tgl)
  );

  function automatic logic [17:0] pat(input logic [9:0] c);
    return {c[5:0] ^ 6'h2A, c[5:0], ~c[5:0]};
  endfunction

  // line buffer model: one clock of read latency
  always @(posedge clk) rd_pix <= pat(rd_col);

  // expected {de, hsync_n, vsync_n, rd_col[9:0], tgl, rgb[17:0]} after edge n
  function automatic logic [31:0] model(input int e);
    int p, h, l, hc, lc;
    logic d, hs, vs, t;
    logic [9:0] c;
    p = e - 1;
    h = p % HT;  l = (p / HT) % VT;
    hc = e % HT; lc = (e / HT) % VT;
    d  = (h < HA) && (l < VA);
    hs = !((h >= HA + HF) && (h < HA + HF + HS));
    vs = !((l >= VA + VF) && (l < VA + VF + VS));
    c  = ((hc < HA) && (lc < VA)) ? 10'(hc) : 10'd0;
    t  = 1'b0;
    for (int q = 0; q < e; q++)
      if ((q % HT == HA) && (((q / HT) % VT < VA - 1) || ((q / HT) % VT == VT - 1)))
        t = ~t;
    return {d, hs, vs, c, t, d ? pat(10'(h)) : 18'd0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic adv(input int target);
    while (n < target) begin
      @(posedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] outs();
    return {de, hsync_n, vsync_n, rd_col, line_req_tgl, red, green, blue};
  endfunction

  // {edge, de, hsync_n, vsync_n, rd_col, tgl}
  localparam int NV = 14;
  localparam logic [29:0] TBL [NV] = '{
    {16'd1,   1'b1, 1'b1, 1'b1, 10'd1, 1'b0},
    {16'd16,  1'b1, 1'b1, 1'b1, 10'd0, 1'b0},
    {16'd17,  1'b0, 1'b1, 1'b1, 10'd0, 1'b1},
    {16'd19,  1'b0, 1'b0, 1'b1, 10'd0, 1'b1},
    {16'd22,  1'b0, 1'b0, 1'b1, 10'd0, 1'b1},
    {16'd23,  1'b0, 1'b1, 1'b1, 10'd0, 1'b1},
    {16'd26,  1'b1, 1'b1, 1'b1, 10'd1, 1'b1},
    {16'd151, 1'b0, 1'b1, 1'b1, 10'd0, 1'b1},
    {16'd201, 1'b0, 1'b1, 1'b0, 10'd0, 1'b1},
    {16'd251, 1'b0, 1'b1, 1'b1, 10'd0, 1'b1},
    {16'd301, 1'b0, 1'b1, 1'b1, 10'd0, 1'b1},
    {16'd317, 1'b0, 1'b1, 1'b1, 10'd0, 1'b0},
    {16'd326, 1'b1, 1'b1, 1'b1, 10'd1, 1'b0},
    {16'd340, 1'b1, 1'b1, 1'b1, 10'd15, 1'b0}
  };

  initial begin
    #(PERIOD * 50000);
    errors++;
    $display("FAIL watchdog expired at edge %0d", n);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] m;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 reset", {18'd0, outs()[31:18]}, {18'd0, 1'b0, 1'b1, 1'b1, 10'd0, 1'b0});
    rst = 1'b0;
    n = 0;

    // R2 R3 R4 R5 R6 R8: hand-computed points, R7 colour on the same points
    for (int i = 0; i < NV; i++) begin
      adv(int'(TBL[i][29:14]));
      chk("R2/R3/R4/R5/R6/R8 table", {18'd0, outs()[31:18]}, {18'd0, TBL[i][13:0]});
      m = model(n);
      chk("R7 rgb", {14'd0, outs()[17:0]}, {14'd0, m[17:0]});
    end

    // R1: reset in mid-line
    adv(n + 7);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 midrun", {18'd0, outs()[31:18]}, {18'd0, 1'b0, 1'b1, 1'b1, 10'd0, 1'b0});
    chk("R7 blank rgb", {14'd0, outs()[17:0]}, 32'd0);
    rst = 1'b0;
    n = 0;

    // R2..R8 every clock over two frames
    for (int e = 1; e <= 2 * HT * VT + 5; e++) begin
      adv(e);
      chk("R2/R3/R4/R5/R6/R7/R8 sweep", outs(), model(e));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule